// File: doc/BRIEF.md
# Sensor Fault Supervisor

This block watches the health of a sensor front end and reports it on one status line. It takes three fault sources. The first is a low-supply flag from an analog detector. The second is a failure flag that the block produces itself by counting edges of a monitored clock. The third is the parity of a stored trim word. Any one of them sets a sticky fault latch.

The host clears the latch by holding the self-test input high for a qualified minimum time, measured in reference-clock cycles. The clear is refused while any fault is still present. The status output is the latch ORed with the self-test input, so driving self-test high also checks the wiring of both pins. A separate validity flag tells the host when status can be trusted: that happens after the first self-test rising edge following reset.

Top module: `sensor_fault_supervisor`

## Requirements
- R1: The fault latch sets when the synchronised low-supply flag is high, the clock monitor reports failure, or the registered trim parity is odd. It stays set after the cause goes away.
- R2: `status` equals the fault latch ORed with `self_test`, so `status` is 1 whenever `self_test` is 1.
- R3: A self-test high time of at least ST_MIN_US microseconds clears the latch. With the bench settings (1 MHz reference, 20 us) a 20-cycle pulse clears it, and a 19-cycle or 5-cycle pulse leaves it set.
- R4: A qualified clear has no effect while any fault condition is present. The latch stays set.
- R5: `status_valid` is 0 from reset until the first synchronised rising edge of `self_test`. After that it stays 1.
- R6: The clock monitor counts rising edges of `mon_clk` over a window of CLKMON_WINDOW reference cycles. It reports failure when the count is below CLKMON_MIN_EDGES, and this includes a stopped clock.
- R7: The trim parity is the XOR of all TRIM_W bits of `trim_word`, registered once. When the word becomes odd, the latch is set one cycle later, which is the second rising edge after the change. An even word (for example 0x0003 or 0xFFFF) raises no fault.
- R8: Reset leaves the latch set, so `status` is 1 right after reset.
- R9: `low_supply` passes through a two-stage synchroniser. When it rises, `status` is still 0 after two reference edges and is 1 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_supply | input | 1 | Asynchronous low-supply detect flag |
| mon_clk | input | 1 | Clock whose frequency is monitored |
| trim_word | input | TRIM_W | Stored trim bits checked for parity |
| self_test | input | 1 | Asynchronous self-test request |
| status | output | 1 | Fault latch ORed with self-test |
| status_valid | output | 1 | High once status is meaningful |

## Verification
The assertions assume that `rst_n` is held low over the first clock edge. They also assume that `mon_clk` runs slower than half the reference clock, so that the two-flop sampler sees every edge. The stimulus meets both conditions: the bench drives the monitored clock no faster than one toggle every two reference cycles, and it changes every asynchronous input only on the falling edge. Before each clear pulse, the bench waits more than two monitor windows after any change in clock rate, so the failure flag has settled before the check.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   typedef struct packed {
      logic supply;
      logic clock;
      logic parity;
   } fault_vec_t;

   function automatic logic any_fault(input fault_vec_t f);
      return f.supply | f.clock | f.parity;
   endfunction
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   initial assert (STAGES >= 2) else $error("sfs_sync: STAGES must be at least 2");

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_parity.sv
module sfs_parity #(
   parameter int TRIM_W     = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIM_W-1:0] word,
   output logic              odd
);
   initial assert (TRIM_W >= 1) else $error("sfs_parity: TRIM_W must be positive");

   logic odd_comb;
   assign odd_comb = ^word;

   generate
      if (REGISTERED) begin : g_reg
         logic odd_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) odd_q <= 1'b0;
            else        odd_q <= odd_comb;
         assign odd = odd_q;
         // R7: the registered flag follows the word one cycle later
         assert_parity_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (^word) |=> odd);
      end else begin : g_comb
         assign odd = odd_comb;
      end
   endgenerate
endmodule

// File: rtl/sfs_clk_monitor.sv
module sfs_clk_monitor #(
   parameter int WINDOW_CYCLES = 100_000,
   parameter int MIN_EDGES     = 50,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_clk,
   output logic clk_fail
);
   localparam int WW = $clog2(WINDOW_CYCLES + 1);
   localparam int EW = $clog2(MIN_EDGES + 1);
   localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYCLES - 1);
   localparam logic [EW-1:0] EDGE_MIN = EW'(MIN_EDGES);

   initial assert (MIN_EDGES >= 1 && MIN_EDGES < WINDOW_CYCLES)
      else $error("sfs_clk_monitor: MIN_EDGES must lie in 1..WINDOW_CYCLES-1");

   logic          mon_s, mon_d;
   logic          mon_rise;
   logic [WW-1:0] win_cnt;
   logic [EW-1:0] edge_cnt;
   logic          win_end;

   sfs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_mon_sync (
      .clk(clk), .rst_n(rst_n), .d(mon_clk), .q(mon_s));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mon_d <= 1'b0;
      else        mon_d <= mon_s;

   assign mon_rise = mon_s & ~mon_d;
   assign win_end  = (win_cnt == WIN_LAST);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       win_cnt <= '0;
      else if (win_end) win_cnt <= '0;
      else              win_cnt <= win_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           edge_cnt <= '0;
      else if (win_end)                     edge_cnt <= '0;
      else if (mon_rise && edge_cnt != EDGE_MIN) edge_cnt <= edge_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       clk_fail <= 1'b0;
      else if (win_end) clk_fail <= (edge_cnt < EDGE_MIN);

   // R6: the window counter never leaves its range
   assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt <= WIN_LAST);
   // R6: the failure flag only moves at a window boundary
   assert_fail_at_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(win_end) |-> $stable(clk_fail));
endmodule

// File: rtl/sfs_st_qual.sv
module sfs_st_qual #(
   parameter int MIN_CYCLES  = 10_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic st_in,
   output logic st_rise,
   output logic clear_req
);
   localparam int CW = $clog2(MIN_CYCLES + 1);
   localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_CYCLES);
   localparam logic [CW-1:0] CNT_QUAL = CW'(MIN_CYCLES - 1);

   initial assert (MIN_CYCLES >= 2) else $error("sfs_st_qual: MIN_CYCLES must be at least 2");

   logic          st_s, st_d;
   logic [CW-1:0] high_cnt;

   sfs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_st_sync (
      .clk(clk), .rst_n(rst_n), .d(st_in), .q(st_s));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st_d <= 1'b0;
      else        st_d <= st_s;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  high_cnt <= '0;
      else if (!st_s)              high_cnt <= '0;
      else if (high_cnt != CNT_MAX) high_cnt <= high_cnt + 1'b1;

   assign st_rise   = st_s & ~st_d;
   assign clear_req = st_s && (high_cnt == CNT_QUAL);

   // R3: a clear request needs self-test held since the previous cycle
   assert_clear_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |-> st_d);
   // R3: at most one request per pulse
   assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |=> !clear_req);
endmodule

// File: rtl/sensor_fault_supervisor.sv
module sensor_fault_supervisor #(
   parameter int TRIM_W           = 16,
   parameter int REF_CLK_HZ       = 100_000_000,
   parameter int ST_MIN_US        = 100,
   parameter int CLKMON_WINDOW    = 100_000,
   parameter int CLKMON_MIN_EDGES = 50,
   parameter int SYNC_STAGES      = 2,
   parameter bit PARITY_REG       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              low_supply,
   input  logic              mon_clk,
   input  logic [TRIM_W-1:0] trim_word,
   input  logic              self_test,
   output logic              status,
   output logic              status_valid
);
   import sfs_pkg::*;

   localparam int ST_MIN_CYCLES = (REF_CLK_HZ / 1_000_000) * ST_MIN_US;

   initial assert (REF_CLK_HZ >= 1_000_000) else $error("reference clock below 1 MHz");

   fault_vec_t faults;
   logic       fault_now;
   logic       fault_latch;
   logic       st_rise, clear_req;
   logic       valid_q;

   sfs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_supply_sync (
      .clk(clk), .rst_n(rst_n), .d(low_supply), .q(faults.supply));

   sfs_clk_monitor #(
      .WINDOW_CYCLES(CLKMON_WINDOW),
      .MIN_EDGES(CLKMON_MIN_EDGES),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_clkmon (
      .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .clk_fail(faults.clock));

   sfs_parity #(.TRIM_W(TRIM_W), .REGISTERED(PARITY_REG)) u_parity (
      .clk(clk), .rst_n(rst_n), .word(trim_word), .odd(faults.parity));

   sfs_st_qual #(.MIN_CYCLES(ST_MIN_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_stq (
      .clk(clk), .rst_n(rst_n), .st_in(self_test), .st_rise(st_rise), .clear_req(clear_req));

   assign fault_now = any_fault(faults);

   // faults dominate a clear request; reset leaves the latch set
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         fault_latch <= 1'b1;
      else if (fault_now) fault_latch <= 1'b1;
      else if (clear_req) fault_latch <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       valid_q <= 1'b0;
      else if (st_rise) valid_q <= 1'b1;

   assign status       = fault_latch | self_test;
   assign status_valid = valid_q;

   // R1: any present fault is latched on the next edge
   assert_fault_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fault_now |=> fault_latch);
   // R3: the latch falls only after a qualified request
   assert_clear_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_latch) |-> $past(clear_req));
   // R4: the latch never falls while a fault was present
   assert_no_clear_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_latch) |-> !$past(fault_now));
   // R5: validity is sticky once reached
   assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |=> status_valid);
   // R5: validity rises only after a synchronised self-test edge
   assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_valid) |-> $past(st_rise));
endmodule

// File: tb/sensor_fault_supervisor_test.sv
module sensor_fault_supervisor_test;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          low_supply = 1'b0;
   logic          mon_clk = 1'b0;
   logic [TW-1:0] trim_word = '0;
   logic          self_test = 1'b0;
   logic          status, status_valid;

   int tests = 0;
   int fails = 0;
   int mon_mode = 1;  // 0 stopped, 1 normal, 2 slow
   int mon_div = 0;

   always #5 clk = ~clk;

   // monitored clock: normal toggles every 2 cycles (16 edges/window), slow every 32 (1 edge/window)
   always @(negedge clk) begin
      if (mon_mode != 0) begin
         mon_div = mon_div + 1;
         if (mon_div >= ((mon_mode == 1) ? 2 : 32)) begin
            mon_clk = ~mon_clk;
            mon_div = 0;
         end
      end
   end

   sensor_fault_supervisor #(
      .TRIM_W(TW), .REF_CLK_HZ(1_000_000), .ST_MIN_US(20),
      .CLKMON_WINDOW(64), .CLKMON_MIN_EDGES(4)
   ) uut (
      .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .mon_clk(mon_clk),
      .trim_word(trim_word), .self_test(self_test),
      .status(status), .status_valid(status_valid));

   // vector: {trim[15:0], low_supply, mode[1:0], pulse_len[7:0], expected_status}
   localparam int NV = 13;
   localparam logic [27:0] VEC [NV] = '{
      {16'h0000, 1'b0, 2'd1, 8'd30, 1'b0},   // R3 clean clear
      {16'h0001, 1'b0, 2'd1, 8'd30, 1'b1},   // R7 R4 odd parity blocks clear
      {16'h0003, 1'b0, 2'd1, 8'd30, 1'b0},   // R7 even word
      {16'h0000, 1'b1, 2'd1, 8'd30, 1'b1},   // R1 R4 supply fault
      {16'h0000, 1'b0, 2'd1, 8'd30, 1'b0},   // R1 cleared after removal
      {16'h0000, 1'b0, 2'd0, 8'd30, 1'b1},   // R6 stopped clock
      {16'h0000, 1'b0, 2'd1, 8'd30, 1'b0},   // R6 recovered
      {16'h0000, 1'b0, 2'd2, 8'd30, 1'b1},   // R6 slow clock
      {16'h0000, 1'b0, 2'd1, 8'd19, 1'b1},   // R3 19 cycles too short
      {16'h0000, 1'b0, 2'd1, 8'd20, 1'b0},   // R3 20 cycles enough
      {16'h8000, 1'b0, 2'd1, 8'd30, 1'b1},   // R7 msb odd
      {16'h0000, 1'b0, 2'd1, 8'd5,  1'b1},   // R3 short pulse
      {16'hFFFF, 1'b0, 2'd1, 8'd30, 1'b0}    // R7 all ones even
   };

   task automatic check(input logic got, input logic exp, input string req);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int len);
      self_test = 1'b1;
      cycles(len);
      self_test = 1'b0;
   endtask

   task automatic run_all();
      cycles(3);
      check(status, 1'b1, "R8 status after reset");
      check(status_valid, 1'b0, "R5 invalid before self-test");
      rst_n = 1'b1;
      cycles(200);
      check(status_valid, 1'b0, "R5 invalid without edge");
      // short pulse: latch kept, validity reached
      self_test = 1'b1;
      cycles(1);
      check(status, 1'b1, "R2 status high with self-test");
      cycles(4);
      self_test = 1'b0;
      cycles(5);
      check(status_valid, 1'b1, "R5 valid after first edge");
      check(status, 1'b1, "R3 short pulse keeps latch");
      // qualified pulse clears
      pulse(25);
      cycles(5);
      check(status, 1'b0, "R3 qualified pulse clears");
      self_test = 1'b1;
      cycles(1);
      check(status, 1'b1, "R2 status follows self-test with latch clear");
      self_test = 1'b0;
      cycles(5);
      check(status, 1'b0, "R2 status low again");
      // supply synchroniser latency
      low_supply = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(status, 1'b0, "R9 not yet after two edges");
      cycles(1);
      check(status, 1'b1, "R9 set after third edge");
      low_supply = 1'b0;
      cycles(5);
      check(status, 1'b1, "R1 latch holds after cause gone");
      pulse(25);
      cycles(5);
      check(status, 1'b0, "R1 cleared");
      // parity latency
      trim_word = 16'h0010;
      cycles(1);
      check(status, 1'b0, "R7 not yet after one edge");
      cycles(1);
      check(status, 1'b1, "R7 set after second edge");
      trim_word = '0;
      cycles(3);
      pulse(25);
      cycles(5);
      check(status, 1'b0, "R7 cleared after even");
      // table walk
      for (int i = 0; i < NV; i++) begin
         trim_word  = VEC[i][27:12];
         low_supply = VEC[i][11];
         mon_mode   = int'(VEC[i][10:9]);
         cycles(200);
         pulse(int'(VEC[i][8:1]));
         cycles(10);
         check(status, VEC[i][0], $sformatf("R1/R3/R4/R6/R7 vector %0d", i));
      end
      check(status_valid, 1'b1, "R5 valid stays high");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule